// File: doc/BRIEF.md
# Boot Configuration Sequencer

This block decides when the switch core leaves fundamental reset. On the first clock after reset it reads the operating-mode straps, a halt strap and two common-clock straps, and keeps those values until the next reset. In preload mode it then asks a shared serial-bus transaction engine for 16-bit words from an external configuration EEPROM, one word at a time. It parses them as a record count followed by address/data records, and each record overwrites the default value of one configuration register.

The core reset output stays low until the preload has finished and the halt bit is clear. While the halt bit is set, the register access port stays usable, so management software can inspect and patch registers. Writing zero to the halt bit then lets the core start. The power-on values of the two slot-clock status bits come from the common-clock straps, and software may later overwrite them. The bit-level serial signalling, the link layers and the switching datapath sit outside this block.

Top module: `boot_cfg_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst_n`, `cfg_done`, `req_valid`, `mode_err` and `load_err` are all 0. Asserting `rst_n` low at any point, including during a preload, abandons the sequence and restores every register to its reset value.
- R2: Mode strap code 0 selects plain boot (no EEPROM reads). Code 1 selects EEPROM preload. Codes 2 to 7 behave as code 0 and also set `mode_err`, which stays set until reset. Outside preload mode `req_valid` never rises.
- R3: All straps are sampled once, on the first rising clock edge with `rst_n` high. Later strap changes have no effect until the next reset.
- R4: The preload reads EEPROM word addresses 0, 1, 2, … in order. Word 0 is the record count N. Each record is three words: register address, data bits 31:16, data bits 15:0. The data is written to configuration register k when the address is below NREG (8). Any other address is ignored. A preload therefore issues 1+3N requests.
- R5: A record count of 0 ends the preload after exactly one request.
- R6: A response with `rsp_err` set aborts the preload and sets `load_err` (sticky until reset). Records already written stay written, the other registers keep their defaults, and the boot still completes.
- R7: After reset, configuration register k (address k, 0 ≤ k < 8) reads DEF_BASE + k, with DEF_BASE = 32'hC0F6_0000.
- R8: When the halt strap was sampled high, `core_rst_n` stays 0 whatever the preload state. Register reads and writes through the sw_ port work meanwhile.
- R9: The halt flag is bit 0 of the control register at address 0x0080. Writing 0 to that bit clears it. Writing 1 has no effect. Bit 1 of that register reads `mode_err` and bit 2 reads `load_err`.
- R10: `core_rst_n` rises only after the preload (if any) has ended and the halt flag is clear. It rises in the same cycle as a one-cycle `cfg_done` pulse, then stays high until reset.
- R11: Bit 0 of the upstream link status register (0x0081) and of the downstream link status register (0x0082) power up with the sampled upstream and downstream common-clock straps. A software write replaces them.
- R12: `req_valid` with `req_addr` stays asserted and unchanged until the cycle in which `rsp_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fundamental reset, active low, asynchronous |
| mode_strap | input | 3 | Operating-mode strap |
| halt_strap | input | 1 | Halt-in-reset strap |
| cclk_up_strap | input | 1 | Upstream common-clock strap |
| cclk_dn_strap | input | 1 | Downstream common-clock strap |
| req_valid | output | 1 | EEPROM word read request to the transaction engine |
| req_addr | output | 16 | EEPROM word address of the request |
| rsp_valid | input | 1 | Response strobe from the transaction engine |
| rsp_data | input | 16 | Word returned with the response |
| rsp_err | input | 1 | NACK or timeout reported with the response |
| sw_we | input | 1 | Register write strobe from the management bus |
| sw_addr | input | 16 | Register write address |
| sw_wdata | input | 32 | Register write data |
| sw_rd_addr | input | 16 | Register read address |
| sw_rdata | output | 32 | Register read data (combinational) |
| core_rst_n | output | 1 | Reset to the switch core, active low |
| cfg_done | output | 1 | One-cycle pulse when the core is released |
| mode_err | output | 1 | Reserved mode code was sampled |
| load_err | output | 1 | Preload was aborted by an engine error |

## Verification
The assertions assume the transaction engine answers only while a request is pending and gives exactly one `rsp_valid` per request. They also assume management software never sets the halt bit again after the core has been released; the hardware prevents that anyway. The bench's EEPROM responder waits for `req_valid` and answers after a fixed delay with a single-cycle strobe. It drops its answer if reset arrives in the meantime. All stimulus is driven on the falling edge.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

   typedef enum logic [1:0] {
      LD_IDLE,
      LD_FETCH,
      LD_END
   } ld_state_e;

   typedef enum logic [1:0] {
      PH_COUNT,
      PH_ADDR,
      PH_DHI,
      PH_DLO
   } ld_phase_e;

   localparam int unsigned MODE_CODE_PLAIN  = 0;
   localparam int unsigned MODE_CODE_EEPROM = 1;

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch #(
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_pin,
   output logic              capture,
   output logic              taken,
   output logic              eeprom_en,
   output logic              mode_err
);
   import boot_cfg_pkg::*;

   localparam logic [MODE_W-1:0] CODE_PLAIN  = MODE_W'(MODE_CODE_PLAIN);
   localparam logic [MODE_W-1:0] CODE_EEPROM = MODE_W'(MODE_CODE_EEPROM);

   assign capture = !taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken     <= 1'b0;
         eeprom_en <= 1'b0;
         mode_err  <= 1'b0;
      end else if (!taken) begin
         taken     <= 1'b1;
         eeprom_en <= (mode_pin == CODE_EEPROM);
         mode_err  <= (mode_pin != CODE_PLAIN) && (mode_pin != CODE_EEPROM);
      end
   end

endmodule

// File: rtl/boot_eeprom_loader.sv
module boot_eeprom_loader #(
   parameter int WORD_W = 16,
   parameter int EE_AW  = 16,
   parameter int AW     = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              eeprom_en,
   output logic              req_valid,
   output logic [EE_AW-1:0]  req_addr,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   input  logic              rsp_err,
   output logic              ld_we,
   output logic [AW-1:0]     ld_addr,
   output logic [DATA_W-1:0] ld_wdata,
   output logic              load_err,
   output logic              finished
);
   import boot_cfg_pkg::*;

   ld_state_e         state_q;
   ld_phase_e         phase_q;
   logic [EE_AW-1:0]  ptr_q;
   logic [WORD_W-1:0] remain_q;
   logic [AW-1:0]     tgt_q;
   logic [WORD_W-1:0] hi_q;
   logic              take;

   assign req_valid = (state_q == LD_FETCH);
   assign req_addr  = ptr_q;
   assign finished  = (state_q == LD_END);
   assign take      = req_valid && rsp_valid;

   assign ld_we    = take && !rsp_err && (phase_q == PH_DLO);
   assign ld_addr  = tgt_q;
   assign ld_wdata = {hi_q, rsp_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= LD_IDLE;
         phase_q  <= PH_COUNT;
         ptr_q    <= '0;
         remain_q <= '0;
         tgt_q    <= '0;
         hi_q     <= '0;
         load_err <= 1'b0;
      end else begin
         case (state_q)
            LD_IDLE: begin
               if (start) state_q <= eeprom_en ? LD_FETCH : LD_END;
            end
            LD_FETCH: begin
               if (take) begin
                  if (rsp_err) begin
                     load_err <= 1'b1;
                     state_q  <= LD_END;
                  end else begin
                     ptr_q <= ptr_q + 1'b1;
                     case (phase_q)
                        PH_COUNT: begin
                           remain_q <= rsp_data;
                           if (rsp_data == '0) state_q <= LD_END;
                           else                phase_q <= PH_ADDR;
                        end
                        PH_ADDR: begin
                           tgt_q   <= rsp_data[AW-1:0];
                           phase_q <= PH_DHI;
                        end
                        PH_DHI: begin
                           hi_q    <= rsp_data;
                           phase_q <= PH_DLO;
                        end
                        default: begin
                           remain_q <= remain_q - 1'b1;
                           phase_q  <= PH_ADDR;
                           if (remain_q == WORD_W'(1)) state_q <= LD_END;
                        end
                     endcase
                  end
               end
            end
            default: state_q <= LD_END;
         endcase
      end
   end

endmodule

// File: rtl/boot_cfg_regs.sv
module boot_cfg_regs #(
   parameter int          NREG         = 8,
   parameter int          DATA_W       = 32,
   parameter int          AW           = 16,
   parameter logic [31:0] DEF_BASE     = 32'hC0F6_0000,
   parameter logic [15:0] CTL_ADDR     = 16'h0080,
   parameter logic [15:0] LUP_ADDR     = 16'h0081,
   parameter logic [15:0] LDN_ADDR     = 16'h0082,
   parameter bit          LOADER_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              halt_pin,
   input  logic              cclk_up_pin,
   input  logic              cclk_dn_pin,
   input  logic              sw_we,
   input  logic [AW-1:0]     sw_addr,
   input  logic [DATA_W-1:0] sw_wdata,
   input  logic              ld_we,
   input  logic [AW-1:0]     ld_addr,
   input  logic [DATA_W-1:0] ld_wdata,
   input  logic              mode_err,
   input  logic              load_err,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              halt_q
);
   localparam int            IDX_W  = $clog2(NREG);
   localparam logic [AW-1:0] NREG_A = AW'(NREG);
   localparam logic [AW-1:0] CTL_A  = AW'(CTL_ADDR);
   localparam logic [AW-1:0] LUP_A  = AW'(LUP_ADDR);
   localparam logic [AW-1:0] LDN_A  = AW'(LDN_ADDR);

   logic [DATA_W-1:0] cfg_q [NREG];
   logic              sclk_up_q;
   logic              sclk_dn_q;

   for (genvar i = 0; i < NREG; i++) begin : g_cfg
      localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(DEF_BASE + 32'(i));
      logic sw_hit;
      logic ld_hit;
      assign sw_hit = sw_we && (sw_addr == AW'(i));
      assign ld_hit = ld_we && (ld_addr == AW'(i));
      if (LOADER_FIRST) begin : g_ld_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cfg_q[i] <= RST_VAL;
            else if (ld_hit) cfg_q[i] <= ld_wdata;
            else if (sw_hit) cfg_q[i] <= sw_wdata;
         end
      end else begin : g_sw_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cfg_q[i] <= RST_VAL;
            else if (sw_hit) cfg_q[i] <= sw_wdata;
            else if (ld_hit) cfg_q[i] <= ld_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q    <= 1'b0;
         sclk_up_q <= 1'b0;
         sclk_dn_q <= 1'b0;
      end else if (capture) begin
         halt_q    <= halt_pin;
         sclk_up_q <= cclk_up_pin;
         sclk_dn_q <= cclk_dn_pin;
      end else if (sw_we) begin
         if (sw_addr == CTL_A) halt_q    <= halt_q & sw_wdata[0];
         if (sw_addr == LUP_A) sclk_up_q <= sw_wdata[0];
         if (sw_addr == LDN_A) sclk_dn_q <= sw_wdata[0];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr < NREG_A)      rd_data = cfg_q[rd_addr[IDX_W-1:0]];
      else if (rd_addr == CTL_A) rd_data = {{(DATA_W-3){1'b0}}, load_err, mode_err, halt_q};
      else if (rd_addr == LUP_A) rd_data = {{(DATA_W-1){1'b0}}, sclk_up_q};
      else if (rd_addr == LDN_A) rd_data = {{(DATA_W-1){1'b0}}, sclk_dn_q};
   end

endmodule

// File: rtl/boot_cfg_seq.sv
module boot_cfg_seq #(
   parameter int          NREG         = 8,
   parameter int          DATA_W       = 32,
   parameter int          WORD_W       = 16,
   parameter int          AW           = 16,
   parameter int          EE_AW        = 16,
   parameter int          MODE_W       = 3,
   parameter logic [31:0] DEF_BASE     = 32'hC0F6_0000,
   parameter logic [15:0] CTL_ADDR     = 16'h0080,
   parameter logic [15:0] LUP_ADDR     = 16'h0081,
   parameter logic [15:0] LDN_ADDR     = 16'h0082,
   parameter bit          LOADER_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_strap,
   input  logic              halt_strap,
   input  logic              cclk_up_strap,
   input  logic              cclk_dn_strap,
   output logic              req_valid,
   output logic [EE_AW-1:0]  req_addr,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   input  logic              rsp_err,
   input  logic              sw_we,
   input  logic [AW-1:0]     sw_addr,
   input  logic [DATA_W-1:0] sw_wdata,
   input  logic [AW-1:0]     sw_rd_addr,
   output logic [DATA_W-1:0] sw_rdata,
   output logic              core_rst_n,
   output logic              cfg_done,
   output logic              mode_err,
   output logic              load_err
);

   if (DATA_W != 2 * WORD_W) begin : g_bad_data_w
      $error("DATA_W must be twice WORD_W");
   end
   if (AW > WORD_W) begin : g_bad_aw
      $error("AW must not exceed WORD_W");
   end
   if (NREG < 2 || NREG > 128) begin : g_bad_nreg
      $error("NREG must lie in 2..128");
   end
   if (MODE_W < 2) begin : g_bad_mode_w
      $error("MODE_W must be at least 2");
   end

   logic              capture;
   logic              taken;
   logic              eeprom_en;
   logic              halt_q;
   logic              ld_finished;
   logic              ld_we;
   logic [AW-1:0]     ld_addr;
   logic [DATA_W-1:0] ld_wdata;
   logic              run_q;
   logic              done_q;

   boot_strap_latch #(.MODE_W(MODE_W)) u_straps (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_pin  (mode_strap),
      .capture   (capture),
      .taken     (taken),
      .eeprom_en (eeprom_en),
      .mode_err  (mode_err)
   );

   boot_eeprom_loader #(
      .WORD_W (WORD_W),
      .EE_AW  (EE_AW),
      .AW     (AW),
      .DATA_W (DATA_W)
   ) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (taken),
      .eeprom_en (eeprom_en),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_err   (rsp_err),
      .ld_we     (ld_we),
      .ld_addr   (ld_addr),
      .ld_wdata  (ld_wdata),
      .load_err  (load_err),
      .finished  (ld_finished)
   );

   boot_cfg_regs #(
      .NREG         (NREG),
      .DATA_W       (DATA_W),
      .AW           (AW),
      .DEF_BASE     (DEF_BASE),
      .CTL_ADDR     (CTL_ADDR),
      .LUP_ADDR     (LUP_ADDR),
      .LDN_ADDR     (LDN_ADDR),
      .LOADER_FIRST (LOADER_FIRST)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (capture),
      .halt_pin    (halt_strap),
      .cclk_up_pin (cclk_up_strap),
      .cclk_dn_pin (cclk_dn_strap),
      .sw_we       (sw_we),
      .sw_addr     (sw_addr),
      .sw_wdata    (sw_wdata),
      .ld_we       (ld_we),
      .ld_addr     (ld_addr),
      .ld_wdata    (ld_wdata),
      .mode_err    (mode_err),
      .load_err    (load_err),
      .rd_addr     (sw_rd_addr),
      .rd_data     (sw_rdata),
      .halt_q      (halt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!run_q && ld_finished && !halt_q) begin
            run_q  <= 1'b1;
            done_q <= 1'b1;
         end
      end
   end

   assign core_rst_n = run_q;
   assign cfg_done   = done_q;

endmodule

// File: rtl/boot_cfg_seq_chk.sv
module boot_cfg_seq_chk #(
   parameter int EE_AW = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             core_rst_n,
   input logic             cfg_done,
   input logic             req_valid,
   input logic [EE_AW-1:0] req_addr,
   input logic             rsp_valid,
   input logic             halt_q,
   input logic             finished,
   input logic             eeprom_en
);

   // R10
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> !cfg_done);

   // R10
   done_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |-> (core_rst_n && !$past(core_rst_n)));

   // R10
   release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_n |=> core_rst_n);

   // R10
   release_waits_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !finished |-> !core_rst_n);

   // R8
   halt_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !core_rst_n);

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr)));

   // R2
   no_fetch_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eeprom_en |-> !req_valid);

endmodule

bind boot_cfg_seq boot_cfg_seq_chk #(.EE_AW(EE_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_rst_n (core_rst_n),
   .cfg_done   (cfg_done),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .halt_q     (halt_q),
   .finished   (ld_finished),
   .eeprom_en  (eeprom_en)
);

// File: tb/tb_boot_cfg_seq.sv
module tb_boot_cfg_seq;

   localparam logic [31:0] DEF  = 32'hC0F6_0000;
   localparam logic [15:0] CTL  = 16'h0080;
   localparam logic [15:0] LUP  = 16'h0081;
   localparam logic [15:0] LDN  = 16'h0082;
   localparam int          LAT  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_strap = 3'd0;
   logic        halt_strap = 1'b0;
   logic        cclk_up_strap = 1'b0;
   logic        cclk_dn_strap = 1'b0;
   logic        req_valid;
   logic [15:0] req_addr;
   logic        rsp_valid = 1'b0;
   logic [15:0] rsp_data = '0;
   logic        rsp_err = 1'b0;
   logic        sw_we = 1'b0;
   logic [15:0] sw_addr = '0;
   logic [31:0] sw_wdata = '0;
   logic [15:0] sw_rd_addr = '0;
   logic [31:0] sw_rdata;
   logic        core_rst_n;
   logic        cfg_done;
   logic        mode_err;
   logic        load_err;

   int n_chk = 0;
   int n_fail = 0;
   int n_req = 0;
   int words_total = 0;
   int err_at = -1;
   bit model_halt = 0;
   bit model_ee = 0;
   bit all_done = 0;
   logic [15:0] img[$];
   logic [31:0] exp_reg[8];

   always #2 clk = ~clk;

   boot_cfg_seq dut (
      .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .halt_strap(halt_strap),
      .cclk_up_strap(cclk_up_strap), .cclk_dn_strap(cclk_dn_strap),
      .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_err(rsp_err), .sw_we(sw_we), .sw_addr(sw_addr),
      .sw_wdata(sw_wdata), .sw_rd_addr(sw_rd_addr), .sw_rdata(sw_rdata),
      .core_rst_n(core_rst_n), .cfg_done(cfg_done), .mode_err(mode_err),
      .load_err(load_err)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // EEPROM responder: answers each request after LAT cycles with a 1-cycle strobe
   initial begin
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0;
         rsp_err   = 1'b0;
         if (rst_n && req_valid) begin
            automatic int a = int'(req_addr);
            chk(a == n_req, "R4 sequential word address", 32'(a), 32'(n_req));
            repeat (LAT - 1) @(negedge clk);
            if (rst_n) begin
               rsp_valid = 1'b1;
               rsp_data  = (a < img.size()) ? img[a] : 16'hFFFF;
               rsp_err   = (a == err_at);
               n_req++;
            end
         end
      end
   end

   // per-clock reference comparison
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (model_halt || (model_ee && n_req < words_total))
               chk(core_rst_n == 1'b0, "R10 core held in reset", 32'(core_rst_n), 32'd0);
            if (!model_ee)
               chk(req_valid == 1'b0, "R2 no EEPROM request", 32'(req_valid), 32'd0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!all_done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      sw_rd_addr = a;
      #1;
      d = sw_rdata;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      sw_we = 1'b1; sw_addr = a; sw_wdata = d;
      @(negedge clk);
      sw_we = 1'b0;
   endtask

   task automatic defaults();
      for (int i = 0; i < 8; i++) exp_reg[i] = DEF + 32'(i);
   endtask

   task automatic start(input logic [2:0] m, input bit h, input bit up, input bit dn,
                        input int words);
      @(negedge clk);
      rst_n = 1'b0;
      mode_strap = m; halt_strap = h; cclk_up_strap = up; cclk_dn_strap = dn;
      n_req = 0;
      words_total = words;
      model_ee = (m == 3'd1);
      model_halt = h;
      defaults();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(core_rst_n == 0 && cfg_done == 0 && req_valid == 0 && mode_err == 0 &&
          load_err == 0, "R1 reset outputs",
          {27'd0, core_rst_n, cfg_done, req_valid, mode_err, load_err}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic wait_release(input int limit, input string req);
      bit seen = 0;
      for (int i = 0; i < limit && !seen; i++) begin
         @(negedge clk);
         if (cfg_done) seen = 1;
      end
      chk(seen, req, 32'(seen), 32'd1);
      chk(core_rst_n == 1'b1, "R10 core released with pulse", 32'(core_rst_n), 32'd1);
      @(negedge clk);
      chk(cfg_done == 1'b0 && core_rst_n == 1'b1, "R10 pulse is one cycle",
          {30'd0, cfg_done, core_rst_n}, 32'd1);
   endtask

   task automatic check_regs(input string req);
      logic [31:0] d;
      for (int i = 0; i < 8; i++) begin
         rd(16'(i), d);
         chk(d == exp_reg[i], req, d, exp_reg[i]);
      end
   endtask

   task automatic push_rec(input logic [15:0] a, input logic [31:0] d);
      img.push_back(a);
      img.push_back(d[31:16]);
      img.push_back(d[15:0]);
   endtask

   initial begin
      logic [31:0] d;

      // A: plain boot, straps, defaults
      img = {};
      err_at = -1;
      start(3'd0, 0, 1, 0, 0);
      wait_release(20, "R2 plain boot completes");
      chk(mode_err == 0 && load_err == 0, "R2 no errors in plain mode",
          {30'd0, mode_err, load_err}, 32'd0);
      chk(n_req == 0, "R2 no requests in plain mode", 32'(n_req), 32'd0);
      check_regs("R7 default register values");
      rd(LUP, d); chk(d == 32'd1, "R11 upstream slot clock from strap", d, 32'd1);
      rd(LDN, d); chk(d == 32'd0, "R11 downstream slot clock from strap", d, 32'd0);
      cclk_up_strap = 1'b0; halt_strap = 1'b1; mode_strap = 3'd5;
      repeat (3) @(negedge clk);
      rd(LUP, d); chk(d == 32'd1, "R3 strap change after sampling ignored", d, 32'd1);
      rd(CTL, d); chk(d == 32'd0, "R3 halt and mode not resampled", d, 32'd0);
      chk(core_rst_n == 1'b1, "R3 core stays running", 32'(core_rst_n), 32'd1);
      wr(LDN, 32'd1);
      rd(LDN, d); chk(d == 32'd1, "R11 software overrides slot clock", d, 32'd1);

      // B: reserved mode code
      start(3'd5, 0, 0, 1, 0);
      wait_release(20, "R2 reserved mode boots as plain");
      chk(mode_err == 1'b1, "R2 reserved mode flags error", 32'(mode_err), 32'd1);
      rd(CTL, d); chk(d == 32'h2, "R9 control register reports mode error", d, 32'h2);
      chk(n_req == 0, "R2 reserved mode makes no requests", 32'(n_req), 32'd0);

      // C: EEPROM preload, three records, one out of range
      img = {};
      img.push_back(16'd3);
      push_rec(16'h0002, 32'h1111_2222);
      push_rec(16'h0090, 32'hDEAD_BEEF);
      push_rec(16'h0006, 32'h3333_4444);
      start(3'd1, 0, 0, 0, 10);
      wait_release(200, "R4 preload completes");
      exp_reg[2] = 32'h1111_2222;
      exp_reg[6] = 32'h3333_4444;
      check_regs("R4 records applied");
      chk(n_req == 10, "R4 request count 1+3N", 32'(n_req), 32'd10);
      rd(CTL, d); chk(d == 32'd0, "R4 out-of-range record ignored", d, 32'd0);

      // D: zero record count
      img = {};
      img.push_back(16'd0);
      start(3'd1, 0, 0, 0, 1);
      wait_release(50, "R5 zero count completes");
      chk(n_req == 1, "R5 single request", 32'(n_req), 32'd1);
      check_regs("R5 defaults kept");

      // E: engine error on word 5
      img = {};
      img.push_back(16'd2);
      push_rec(16'h0003, 32'hAAAA_0001);
      push_rec(16'h0005, 32'hBBBB_0002);
      err_at = 5;
      start(3'd1, 0, 0, 0, 6);
      wait_release(200, "R6 boot completes after error");
      err_at = -1;
      chk(load_err == 1'b1, "R6 load error flagged", 32'(load_err), 32'd1);
      chk(n_req == 6, "R6 loading stops at error", 32'(n_req), 32'd6);
      exp_reg[3] = 32'hAAAA_0001;
      check_regs("R6 earlier record kept, rest default");
      rd(CTL, d); chk(d == 32'h4, "R9 control register reports load error", d, 32'h4);

      // F: halt in plain mode
      img = {};
      start(3'd0, 1, 0, 0, 0);
      repeat (40) @(negedge clk);
      chk(core_rst_n == 1'b0, "R8 halted core stays in reset", 32'(core_rst_n), 32'd0);
      wr(16'h0001, 32'h5555_AAAA);
      rd(16'h0001, d); chk(d == 32'h5555_AAAA, "R8 register access while halted", d, 32'h5555_AAAA);
      wr(CTL, 32'h1);
      repeat (10) @(negedge clk);
      chk(core_rst_n == 1'b0, "R9 writing 1 keeps halt", 32'(core_rst_n), 32'd0);
      rd(CTL, d); chk(d == 32'h1, "R9 halt bit still set", d, 32'h1);
      wr(CTL, 32'h0);
      model_halt = 0;
      wait_release(10, "R9 clearing halt releases core");

      // G: halt cleared during preload; release waits for the load
      img = {};
      img.push_back(16'd2);
      push_rec(16'h0000, 32'h0123_4567);
      push_rec(16'h0007, 32'h89AB_CDEF);
      start(3'd1, 1, 0, 0, 7);
      while (n_req < 2) @(negedge clk);
      wr(CTL, 32'h0);
      model_halt = 0;
      wait_release(200, "R10 release after load with halt cleared early");
      chk(n_req == 7, "R10 all words fetched before release", 32'(n_req), 32'd7);
      exp_reg[0] = 32'h0123_4567;
      exp_reg[7] = 32'h89AB_CDEF;
      check_regs("R10 records applied under halt");

      // H: reset during preload restarts
      img = {};
      img.push_back(16'd2);
      push_rec(16'h0002, 32'hFEED_0001);
      push_rec(16'h0004, 32'hFEED_0002);
      start(3'd1, 0, 0, 0, 7);
      while (n_req < 5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(core_rst_n == 0 && req_valid == 0 && cfg_done == 0,
          "R1 reset mid-load clears outputs",
          {29'd0, core_rst_n, req_valid, cfg_done}, 32'd0);
      img = {};
      start(3'd0, 0, 0, 0, 0);
      wait_release(20, "R1 restart after reset");
      check_regs("R1 restart restores defaults");

      all_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule